// File: doc/BRIEF.md
# Track Demultiplexer, Pair Builder and Lookup Address Router

This block sits between two time-multiplexed 9-bit track buses and a cluster of five lookup RAMs. Each bus delivers two tracks per main cycle, one after the other: the first bus carries tracks A then D, the second carries tracks B then E. Two single-cycle phase strobes on the system clock mark the arrival of the first and second chunks. The first strobe parks the early chunks in holding registers. The second strobe latches the held and current chunks together into four synchronous track registers.

From the four tracks the block forms five fixed 18-bit pair words. Each pair word is extended with a zero bit and a clock-phase bit to make a 20-bit RAM address, so every RAM can perform two lookups per main cycle. When the host asserts the RAM-select input, all five address ports follow the host address instead, so the RAMs can be loaded. A small read-only window lets the host read the demuxed tracks, the raw incoming buses and a build-time version number.

Top module: `trackPairRouter`

## Requirements
- R1: A synchronous reset clears the holding registers, the four track registers and the phase bit. After reset, with RAM-select low, every RAM address port reads 0 and every track offset reads 0.
- R2: On a cycle with `phaseFirst` high, both buses are captured into holding registers. On a cycle with `phaseSecond` high, the tracks latch as A = held first-bus chunk, D = current first-bus value, B = held second-bus chunk and E = current second-bus value. The new tracks are visible from the next cycle. With no `phaseSecond`, the tracks keep their value.
- R3: In pair mode, RAM port p occupies `ramAddr[20p+19:20p]` and holds the low track in bits 8:0 and the high track in bits 17:9. The pairs are: port 0 low A / high D; port 1 low A / high B; port 2 low A / high E; port 3 low B / high D; port 4 low D / high E.
- R4: With parameter `SWAP_AD` = 1, port 0 instead carries B in bits 8:0 and E in bits 17:9. All other ports are unchanged.
- R5: In pair mode, bit 18 of every port is 0. Bit 19 is the phase bit. It becomes 1 in the cycle after `phaseSecond` and 0 in the cycle after a `phaseFirst` that has no `phaseSecond` with it. Otherwise it holds its value.
- R6: While `ramSel` is high, in the same cycle every port carries `{1'b0, hostAddr[20:2]}`.
- R7: `hostRdData` combinationally returns the track selected by `hostAddr[7:0]`: 0x00 returns A, 0x04 returns D, 0x08 returns B and 0x0C returns E. Each is zero-extended from 9 bits.
- R8: In the same cycle, offset 0x10 returns the 4-bit `VERSION`, offset 0x20 returns the raw first bus and offset 0x24 returns the raw second bus. All are zero-extended.
- R9: Any other value of `hostAddr[7:0]`, unaligned values included, returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseFirst | input | 1 | Strobe: first chunk present on both buses |
| phaseSecond | input | 1 | Strobe: second chunk present on both buses |
| busAd | input | 9 | Multiplexed bus carrying tracks A then D |
| busBe | input | 9 | Multiplexed bus carrying tracks B then E |
| ramSel | input | 1 | High selects host address on all RAM ports |
| hostAddr | input | 21 | Host byte address; bits 20:2 feed RAM configuration, bits 7:0 select the read register |
| ramAddr | output | 100 | Five 20-bit RAM addresses, port p at bits 20p+19:20p |
| hostRdData | output | 16 | Read data of the register window |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default pairing with version 3. The other has `SWAP_AD` = 1 and version 5. This puts both pairing variants and two distinct version values under the same reference model in every cycle. Regular and irregular strobe patterns exercise the hold and latch timing and the phase bit. Host-select windows, every mapped offset and a set of unmapped and unaligned offsets cover the routing and read paths. A reset in mid-traffic is also included.

// File: rtl/trackRouterPkg.sv
package trackRouterPkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic captureHold;    // park first chunk of each bus
    logic captureTracks;  // latch all four tracks
    logic phaseBit;       // registered phase for RAM address bit 19
  } routerStrobes_t;

  // Track slot numbering inside the track register array
  localparam int TRK_A = 0;
  localparam int TRK_D = 1;
  localparam int TRK_B = 2;
  localparam int TRK_E = 3;
  localparam int NUM_TRACKS = 4;
  localparam int NUM_PAIRS  = 5;

  // Read window offsets (byte addresses, low 8 bits)
  localparam logic [7:0] OFF_TRK_A   = 8'h00;
  localparam logic [7:0] OFF_TRK_D   = 8'h04;
  localparam logic [7:0] OFF_TRK_B   = 8'h08;
  localparam logic [7:0] OFF_TRK_E   = 8'h0C;
  localparam logic [7:0] OFF_VERSION = 8'h10;
  localparam logic [7:0] OFF_RAW_AD  = 8'h20;
  localparam logic [7:0] OFF_RAW_BE  = 8'h24;

  // Track placed in bits 8:0 of a pair port
  function automatic int pairLoIdx(int port, bit swapAd);
    case (port)
      0:       return swapAd ? TRK_B : TRK_A;
      1:       return TRK_A;
      2:       return TRK_A;
      3:       return TRK_B;
      default: return TRK_D;
    endcase
  endfunction

  // Track placed in bits 17:9 of a pair port
  function automatic int pairHiIdx(int port, bit swapAd);
    case (port)
      0:       return swapAd ? TRK_E : TRK_D;
      1:       return TRK_B;
      2:       return TRK_E;
      3:       return TRK_D;
      default: return TRK_E;
    endcase
  endfunction

endpackage

// File: rtl/trackRouterCtrl.sv
module trackRouterCtrl
  import trackRouterPkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           phaseFirst,
  input  logic           phaseSecond,
  output routerStrobes_t strb
);

  logic phaseBitQ;

  // Phase bit: high for the half after the second strobe, low after the first
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseBitQ <= 1'b0;
    end else if (phaseSecond) begin
      phaseBitQ <= 1'b1;
    end else if (phaseFirst) begin
      phaseBitQ <= 1'b0;
    end
  end

  always_comb begin
    strb.captureHold   = phaseFirst;
    strb.captureTracks = phaseSecond;
    strb.phaseBit      = phaseBitQ;
  end

  assert_phase_set_R5: assert property (@(posedge clk) disable iff (rst)
    phaseSecond |=> strb.phaseBit);

  assert_phase_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (phaseFirst && !phaseSecond) |=> !strb.phaseBit);

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!phaseFirst && !phaseSecond) |=> $stable(strb.phaseBit));

endmodule

// File: rtl/trackRouterDatapath.sv
module trackRouterDatapath
  import trackRouterPkg::*;
#(
  parameter int         TRACK_W = 9,
  parameter int         RD_W    = 16,
  parameter logic [3:0] VERSION = 4'h3,
  parameter bit         SWAP_AD = 1'b0,
  localparam int        PAIR_W  = 2 * TRACK_W,
  localparam int        RAM_AW  = PAIR_W + 2,
  localparam int        HOST_AW = RAM_AW + 1
)(
  input  logic                        clk,
  input  logic                        rst,
  input  routerStrobes_t              strb,
  input  logic [TRACK_W-1:0]          busAd,
  input  logic [TRACK_W-1:0]          busBe,
  input  logic                        ramSel,
  input  logic [HOST_AW-1:0]          hostAddr,
  output logic [NUM_PAIRS*RAM_AW-1:0] ramAddr,
  output logic [RD_W-1:0]             hostRdData
);

  logic [TRACK_W-1:0] holdAdQ;
  logic [TRACK_W-1:0] holdBeQ;
  logic [NUM_TRACKS-1:0][TRACK_W-1:0] trkQ;
  logic [RAM_AW-1:0]  cfgAddr;

  // Holding and track registers
  always_ff @(posedge clk) begin
    if (rst) begin
      holdAdQ <= '0;
      holdBeQ <= '0;
      trkQ    <= '0;
    end else begin
      if (strb.captureHold) begin
        holdAdQ <= busAd;
        holdBeQ <= busBe;
      end
      if (strb.captureTracks) begin
        trkQ[TRK_A] <= holdAdQ;
        trkQ[TRK_D] <= busAd;
        trkQ[TRK_B] <= holdBeQ;
        trkQ[TRK_E] <= busBe;
      end
    end
  end

  assign cfgAddr = {1'b0, hostAddr[HOST_AW-1:2]};

  // Pair words and per-port address select
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_port
    localparam int LO = pairLoIdx(p, SWAP_AD);
    localparam int HI = pairHiIdx(p, SWAP_AD);
    logic [PAIR_W-1:0] pairWord;

    assign pairWord = {trkQ[HI], trkQ[LO]};
    assign ramAddr[p*RAM_AW +: RAM_AW] =
      ramSel ? cfgAddr : {strb.phaseBit, 1'b0, pairWord};

    assert_pair_bit18_R5: assert property (@(posedge clk) disable iff (rst)
      !ramSel |-> (ramAddr[p*RAM_AW + RAM_AW-2] == 1'b0));

    if (p > 0) begin : g_cfgSame
      assert_cfg_all_ports_R6: assert property (@(posedge clk) disable iff (rst)
        ramSel |-> (ramAddr[p*RAM_AW +: RAM_AW] == ramAddr[RAM_AW-1:0]));
    end
  end

  // Read-only register window
  always_comb begin
    hostRdData = '0;
    case (hostAddr[7:0])
      OFF_TRK_A:   hostRdData = RD_W'(trkQ[TRK_A]);
      OFF_TRK_D:   hostRdData = RD_W'(trkQ[TRK_D]);
      OFF_TRK_B:   hostRdData = RD_W'(trkQ[TRK_B]);
      OFF_TRK_E:   hostRdData = RD_W'(trkQ[TRK_E]);
      OFF_VERSION: hostRdData = RD_W'(VERSION);
      OFF_RAW_AD:  hostRdData = RD_W'(busAd);
      OFF_RAW_BE:  hostRdData = RD_W'(busBe);
      default:     hostRdData = '0;
    endcase
  end

  assert_tracks_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.captureTracks |=> $stable(trkQ));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.captureHold |=> ($stable(holdAdQ) && $stable(holdBeQ)));

  assert_rd_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    hostRdData[RD_W-1:TRACK_W] == '0);

  assert_pair_shared_a_R3: assert property (@(posedge clk) disable iff (rst)
    !ramSel |-> (ramAddr[RAM_AW +: TRACK_W] == ramAddr[2*RAM_AW +: TRACK_W]));

endmodule

// File: rtl/trackPairRouter.sv
module trackPairRouter
  import trackRouterPkg::*;
#(
  parameter int         TRACK_W = 9,
  parameter int         RD_W    = 16,
  parameter logic [3:0] VERSION = 4'h3,
  parameter bit         SWAP_AD = 1'b0
)(
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   phaseFirst,
  input  logic                                   phaseSecond,
  input  logic [TRACK_W-1:0]                     busAd,
  input  logic [TRACK_W-1:0]                     busBe,
  input  logic                                   ramSel,
  input  logic [2*TRACK_W+2:0]                   hostAddr,
  output logic [NUM_PAIRS*(2*TRACK_W+2)-1:0]     ramAddr,
  output logic [RD_W-1:0]                        hostRdData
);

  routerStrobes_t strb;

  trackRouterCtrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .phaseFirst  (phaseFirst),
    .phaseSecond (phaseSecond),
    .strb        (strb)
  );

  trackRouterDatapath #(
    .TRACK_W (TRACK_W),
    .RD_W    (RD_W),
    .VERSION (VERSION),
    .SWAP_AD (SWAP_AD)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .busAd      (busAd),
    .busBe      (busBe),
    .ramSel     (ramSel),
    .hostAddr   (hostAddr),
    .ramAddr    (ramAddr),
    .hostRdData (hostRdData)
  );

endmodule

// File: tb/test_trackPairRouter.sv
module test_trackPairRouter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phaseFirst = 1'b0;
  logic        phaseSecond = 1'b0;
  logic [8:0]  busAd = '0;
  logic [8:0]  busBe = '0;
  logic        ramSel = 1'b0;
  logic [20:0] hostAddr = '0;
  logic [99:0] ramAddr0, ramAddr1;
  logic [15:0] rd0, rd1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  trackPairRouter #(.VERSION(4'h3), .SWAP_AD(1'b0)) i_trackPairRouter (
    .clk(clk), .rst(rst), .phaseFirst(phaseFirst), .phaseSecond(phaseSecond),
    .busAd(busAd), .busBe(busBe), .ramSel(ramSel), .hostAddr(hostAddr),
    .ramAddr(ramAddr0), .hostRdData(rd0));

  trackPairRouter #(.VERSION(4'h5), .SWAP_AD(1'b1)) i_trackPairRouter_swap (
    .clk(clk), .rst(rst), .phaseFirst(phaseFirst), .phaseSecond(phaseSecond),
    .busAd(busAd), .busBe(busBe), .ramSel(ramSel), .hostAddr(hostAddr),
    .ramAddr(ramAddr1), .hostRdData(rd1));

  // Behavioural reference state
  int mHoldAd, mHoldBe, mA, mD, mB, mE, mPh;

  always @(posedge clk) begin
    if (rst) begin
      mHoldAd <= 0; mHoldBe <= 0; mA <= 0; mD <= 0; mB <= 0; mE <= 0; mPh <= 0;
    end else begin
      if (phaseFirst) begin mHoldAd <= int'(busAd); mHoldBe <= int'(busBe); end
      if (phaseSecond) begin
        mA <= mHoldAd; mD <= int'(busAd); mB <= mHoldBe; mE <= int'(busBe);
      end
      if (phaseSecond) mPh <= 1;
      else if (phaseFirst) mPh <= 0;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int expPort(int p, bit swap);
    int lo, hi;
    case (p)
      0: begin lo = swap ? mB : mA; hi = swap ? mE : mD; end
      1: begin lo = mA; hi = mB; end
      2: begin lo = mA; hi = mE; end
      3: begin lo = mB; hi = mD; end
      default: begin lo = mD; hi = mE; end
    endcase
    if (ramSel) return int'(hostAddr[20:2]);
    return (mPh << 19) | (hi << 9) | lo;
  endfunction

  function automatic int expRead(int ver);
    case (hostAddr[7:0])
      8'h00: return mA;
      8'h04: return mD;
      8'h08: return mB;
      8'h0C: return mE;
      8'h10: return ver;
      8'h20: return int'(busAd);
      8'h24: return int'(busBe);
      default: return 0;
    endcase
  endfunction

  function automatic string readTag();
    case (hostAddr[7:0])
      8'h00, 8'h04, 8'h08, 8'h0C: return "R7";
      8'h10, 8'h20, 8'h24:         return "R8";
      default:                     return "R9";
    endcase
  endfunction

  task automatic compareAll();
    for (int inst = 0; inst < 2; inst++) begin
      logic [99:0] ra;
      bit sw;
      ra = (inst == 0) ? ramAddr0 : ramAddr1;
      sw = (inst == 1);
      for (int p = 0; p < 5; p++) begin
        int e, a;
        e = expPort(p, sw);
        a = int'(ra[p*20 +: 20]);
        chk(ramSel ? "R6" : ((sw && p == 0) ? "R4" : "R3"),
            $sformatf("inst%0d port%0d low", inst, p), a & 32'h7FFFF, e & 32'h7FFFF);
        chk(ramSel ? "R6" : "R5",
            $sformatf("inst%0d port%0d top", inst, p), a >> 18, e >> 18);
      end
      chk(readTag(), $sformatf("inst%0d read %0h", inst, hostAddr[7:0]),
          int'((inst == 0) ? rd0 : rd1), expRead((inst == 0) ? 3 : 5));
    end
  endtask

  task automatic step(bit r, bit f, bit s, int ad, int be, bit sel, int addr);
    @(negedge clk);
    rst = r; phaseFirst = f; phaseSecond = s;
    busAd = 9'(ad); busBe = 9'(be); ramSel = sel; hostAddr = 21'(addr);
    #1;
    compareAll();
  endtask

  int offs[12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h24,
                   8'h02, 8'h14, 8'h28, 8'hFC, 8'h30};

  function automatic int rndAddr();
    return int'({$urandom} % 21'h1FFF00) & 32'h1FFF00 | offs[$urandom % 12];
  endfunction

  initial begin
    // R1: reset dominates strobes
    for (int i = 0; i < 3; i++) step(1, 1, i == 1, $urandom, $urandom, 0, 0);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    chk("R1", "port0 after reset", int'(ramAddr0[19:0]), 0);
    chk("R1", "track A read after reset", int'(rd0), 0);
    step(0, 0, 0, 0, 0, 0, 8'h0C);
    chk("R1", "track E read after reset", int'(rd1), 0);

    // Regular strobe pattern
    for (int i = 0; i < 60; i++)
      step(0, (i % 4) == 0, (i % 4) == 2, $urandom, $urandom, 0, rndAddr());

    // R2: known values through hold and latch
    step(0, 1, 0, 9'h1AA, 9'h055, 0, 0);
    step(0, 0, 0, 9'h003, 9'h1FF, 0, 0);
    step(0, 0, 1, 9'h123, 9'h0F0, 0, 0);
    step(0, 0, 0, 9'h000, 9'h000, 0, 8'h00);
    chk("R2", "track A", int'(rd0), 9'h1AA);
    step(0, 0, 0, 9'h000, 9'h000, 0, 8'h04);
    chk("R2", "track D", int'(rd0), 9'h123);
    step(0, 0, 0, 9'h000, 9'h000, 0, 8'h08);
    chk("R2", "track B", int'(rd0), 9'h055);
    step(0, 0, 0, 9'h000, 9'h000, 0, 8'h0C);
    chk("R2", "track E", int'(rd0), 9'h0F0);
    chk("R4", "swap port0 high=E low=B", int'(ramAddr1[17:0]), {9'h0F0, 9'h055});
    chk("R5", "phase bit after second strobe", int'(ramAddr0[19]), 1);

    // R6: host select window with traffic continuing
    for (int i = 0; i < 20; i++)
      step(0, (i % 4) == 0, (i % 4) == 2, $urandom, $urandom, 1, rndAddr());

    // Irregular strobes, never both in one cycle
    for (int i = 0; i < 40; i++) begin
      int r;
      r = int'($urandom % 4);
      step(0, r == 0, r == 1, $urandom, $urandom, (i % 9) == 5, rndAddr());
    end

    // Mid-run reset, then recovery
    step(1, 1, 0, $urandom, $urandom, 0, 8'h00);
    for (int i = 0; i < 16; i++)
      step(0, (i % 4) == 1, (i % 4) == 3, $urandom, $urandom, 0, rndAddr());

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule